// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block feeds a transmit path from a ring of two-word descriptors kept in ordinary memory. Software fills descriptors and buffers, then pulses a start command. The engine reads the descriptor at its current ring index and streams the buffer contents out one byte per handshake. It marks the first byte of a frame and the last byte of the frame's final buffer. Once a buffer is done, it stores the descriptor's control word back with the ownership flag set. It then moves to the next descriptor and keeps going until it meets a descriptor that is still marked used.

Each descriptor is two words at word address `RING_BASE + 2*index`. Word 0 holds the buffer byte address, which must be word aligned. Word 1 holds the control word. Two error cases are reported back into the descriptor. The first is a used descriptor met in the middle of a frame. The second is an underrun pulse from the output side. In both cases the stream is closed with a single error beat. A halt request lets the frame in progress finish and then parks the engine. The busy output shows whether any transfer is still running. Frame check sequences, line timing and the bus fabric belong to other blocks. A per-frame no-CRC request only travels alongside the bytes.

The memory port has one cycle of read latency: read data is valid in the cycle after the read strobe.

Top module: `txr_fetch`

## Requirements
- R1: After reset, busy, tx_valid, mem_rd and mem_wr are low and the ring index is 0.
- R2: A start that finds the descriptor at the current index with control bit 31 (used) set returns the engine to idle without emitting a byte and without writing memory.
- R3: A buffer of N bytes (control bits 10:0) is emitted in address order, little-endian within each 32-bit word. tx_sof is high on the first byte of a frame. tx_eof is high on the last byte of a buffer whose control bit 15 (last buffer) is set.
- R4: After each buffer, the control word (descriptor word 1) is written back with bit 31 set and all other bits unchanged.
- R5: A frame may span several descriptors; tx_sof appears only on its first byte and tx_eof only at the end of the buffer carrying bit 15.
- R6: After a frame the engine fetches the following descriptor and sends further frames until it reaches a used descriptor, then it idles.
- R7: The index after a descriptor with control bit 30 (wrap) set, or after index RING_N-1, is 0.
- R8: Control bit 16 (no CRC) of a frame's first descriptor is presented on tx_nocrc with every byte of that frame.
- R9: A used descriptor met mid-frame gets its control word written back with bit 27 set. One beat with tx_eof and tx_err high and data 0 follows, the engine idles, and the index stays on that descriptor.
- R10: An underrun pulse during a frame aborts it. The current descriptor's control word is written with bits 31 and 28 set, an error beat follows, the engine idles, and the index moves past that descriptor. An underrun pulse outside a frame has no effect.
- R11: A halt request during a frame lets that frame complete, including its write-back, and then the engine idles with busy low instead of starting the next frame.
- R12: The ring index is kept across start commands and only reset returns it to 0.
- R13: While tx_valid is high and tx_ready is low, the beat is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command pulse |
| halt_i | input | 1 | Halt request pulse |
| underrun_i | input | 1 | Underrun pulse from the output side |
| busy_o | output | 1 | Transfer in progress |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the strobe |
| tx_valid_o | output | 1 | Output beat valid |
| tx_ready_i | input | 1 | Output beat accepted |
| tx_data_o | output | 8 | Output byte |
| tx_sof_o | output | 1 | First byte of frame |
| tx_eof_o | output | 1 | Last beat of frame |
| tx_err_o | output | 1 | Frame aborted |
| tx_nocrc_o | output | 1 | Frame asks for no CRC |

## Verification
The tests cover these cases:
- a single one-buffer frame, which shows byte order and end marking;
- a two-buffer frame followed by a second frame under a stalling ready pattern, which separates frame markers from buffer boundaries and shows that the beat holds;
- a wrap-flagged descriptor, which shows the index returning to 0.

The error cases check the stored control words and where the next start resumes, so a stalled index can be told apart from an advanced one:
- a used descriptor in the middle of a frame;
- an underrun pulse mid-buffer;
- an underrun pulse while idle.

A halt issued just after start must produce one frame and leave the next descriptor untouched in memory.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;
   localparam int LEN_W = 11;
   localparam logic [31:0] M_LAST  = 32'h0000_8000;
   localparam logic [31:0] M_NOCRC = 32'h0001_0000;
   localparam logic [31:0] M_EXH   = 32'h0800_0000;
   localparam logic [31:0] M_UND   = 32'h1000_0000;
   localparam logic [31:0] M_WRAP  = 32'h4000_0000;
   localparam logic [31:0] M_USED  = 32'h8000_0000;

   typedef enum logic [3:0] {
      S_IDLE, S_FETCH_A, S_FETCH_C, S_EVAL, S_DREQ, S_DCAP, S_EMIT, S_WB, S_ERRB
   } txr_state_e;

   typedef enum logic [1:0] {WB_MID, WB_LAST, WB_EXH, WB_UND} txr_wb_e;
endpackage

// File: rtl/txr_ring_ptr.sv
`timescale 1ns/1ps
module txr_ring_ptr #(
   parameter int N = 16,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             wrap_i,
   output logic [IDX_W-1:0] idx_o
);
   logic [IDX_W-1:0] nxt;

   generate
      if ((2 ** IDX_W) == N) begin : g_pow2
         // natural roll-over covers the last slot
         assign nxt = wrap_i ? '0 : idx_o + 1'b1;
      end else begin : g_cmp
         assign nxt = (wrap_i || idx_o == IDX_W'(N - 1)) ? '0 : idx_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_o <= '0;
      else if (adv_i) idx_o <= nxt;
   end
endmodule

// File: rtl/txr_lane_pick.sv
`timescale 1ns/1ps
module txr_lane_pick #(
   parameter int WORD_W = 32,
   localparam int LANES = WORD_W / 8,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [7:0]        byte_o
);
   logic [7:0] lanes [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lanes[i] = word_i[8*i +: 8];
   end

   assign byte_o = lanes[sel_i];
endmodule

// File: rtl/txr_fetch.sv
`timescale 1ns/1ps
module txr_fetch
   import txr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int RING_N    = 16,
   parameter int RING_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              halt_i,
   input  logic              underrun_i,
   output logic              busy_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic [31:0]       mem_rdata_i,
   output logic              tx_valid_o,
   input  logic              tx_ready_i,
   output logic [7:0]        tx_data_o,
   output logic              tx_sof_o,
   output logic              tx_eof_o,
   output logic              tx_err_o,
   output logic              tx_nocrc_o
);
   localparam int IDX_W = (RING_N > 1) ? $clog2(RING_N) : 1;

   generate
      if (RING_N < 2) begin : g_bad_ring
         $error("txr_fetch: RING_N must be at least 2");
      end
      if (ADDR_W + 2 > 32) begin : g_bad_addr
         $error("txr_fetch: ADDR_W too wide for a 32-bit buffer pointer");
      end
      if (RING_BASE + 2 * RING_N > (2 ** ADDR_W)) begin : g_bad_base
         $error("txr_fetch: ring does not fit the address space");
      end
   endgenerate

   txr_state_e        state;
   txr_wb_e           wb_kind;
   logic [ADDR_W-1:0] buf_ptr;
   logic [LEN_W-1:0]  remain;
   logic [1:0]        lane;
   logic [31:0]       word_q, ctrl_q, status_q;
   logic              in_frame, sof_pend, nocrc_q, halt_pend, under_pend;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] desc_a;
   logic [7:0]        lane_byte;
   logic              und_now, ptr_adv;

   assign desc_a  = ADDR_W'(RING_BASE) + ADDR_W'({idx, 1'b0});
   assign und_now = under_pend || (underrun_i && in_frame);
   assign ptr_adv = (state == S_WB) && (wb_kind != WB_EXH);

   txr_ring_ptr #(.N(RING_N)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv_i(ptr_adv),
      .wrap_i(ctrl_q[30]), .idx_o(idx)
   );

   txr_lane_pick #(.WORD_W(32)) u_lane (
      .word_i(word_q), .sel_i(lane), .byte_o(lane_byte)
   );

   // memory port
   always_comb begin
      mem_rd_o    = 1'b0;
      mem_wr_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = status_q;
      case (state)
         S_FETCH_A: begin mem_rd_o = 1'b1; mem_addr_o = desc_a; end
         S_FETCH_C: begin mem_rd_o = 1'b1; mem_addr_o = desc_a + 1'b1; end
         S_DREQ:    begin mem_rd_o = 1'b1; mem_addr_o = buf_ptr; end
         S_WB:      begin mem_wr_o = 1'b1; mem_addr_o = desc_a + 1'b1; end
         default: ;
      endcase
   end

   // output stream
   assign busy_o     = (state != S_IDLE);
   assign tx_valid_o = (state == S_EMIT) || (state == S_ERRB);
   assign tx_data_o  = (state == S_EMIT) ? lane_byte : 8'h00;
   assign tx_sof_o   = (state == S_EMIT) && sof_pend;
   assign tx_eof_o   = ((state == S_EMIT) && remain == LEN_W'(1) && ctrl_q[15])
                       || (state == S_ERRB);
   assign tx_err_o   = (state == S_ERRB);
   assign tx_nocrc_o = tx_valid_o && nocrc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         wb_kind    <= WB_MID;
         buf_ptr    <= '0;
         remain     <= '0;
         lane       <= '0;
         word_q     <= '0;
         ctrl_q     <= '0;
         status_q   <= '0;
         in_frame   <= 1'b0;
         sof_pend   <= 1'b0;
         nocrc_q    <= 1'b0;
         halt_pend  <= 1'b0;
         under_pend <= 1'b0;
      end else begin
         if (halt_i && state != S_IDLE) halt_pend <= 1'b1;
         if (underrun_i && in_frame)    under_pend <= 1'b1;

         if (und_now && (state == S_DREQ || state == S_DCAP || state == S_EMIT)) begin
            status_q <= ctrl_q | M_USED | M_UND;
            wb_kind  <= WB_UND;
            state    <= S_WB;
         end else begin
            case (state)
               S_IDLE: begin
                  halt_pend  <= 1'b0;
                  under_pend <= 1'b0;
                  if (start_i) state <= S_FETCH_A;
               end
               S_FETCH_A: state <= S_FETCH_C;
               S_FETCH_C: begin
                  buf_ptr <= mem_rdata_i[ADDR_W+1:2];
                  state   <= S_EVAL;
               end
               S_EVAL: begin
                  ctrl_q <= mem_rdata_i;
                  if (mem_rdata_i[31]) begin
                     if (in_frame) begin
                        status_q <= mem_rdata_i | M_EXH;
                        wb_kind  <= WB_EXH;
                        state    <= S_WB;
                     end else begin
                        state <= S_IDLE;
                     end
                  end else if (und_now) begin
                     status_q <= mem_rdata_i | M_USED | M_UND;
                     wb_kind  <= WB_UND;
                     state    <= S_WB;
                  end else begin
                     if (!in_frame) begin
                        in_frame <= 1'b1;
                        sof_pend <= 1'b1;
                        nocrc_q  <= mem_rdata_i[16];
                     end
                     remain   <= mem_rdata_i[LEN_W-1:0];
                     lane     <= '0;
                     status_q <= mem_rdata_i | M_USED;
                     wb_kind  <= mem_rdata_i[15] ? WB_LAST : WB_MID;
                     state    <= (mem_rdata_i[LEN_W-1:0] == '0) ? S_WB : S_DREQ;
                  end
               end
               S_DREQ: state <= S_DCAP;
               S_DCAP: begin
                  word_q <= mem_rdata_i;
                  state  <= S_EMIT;
               end
               S_EMIT: begin
                  if (tx_ready_i) begin
                     sof_pend <= 1'b0;
                     remain   <= remain - 1'b1;
                     lane     <= lane + 1'b1;
                     if (remain == LEN_W'(1)) begin
                        state <= S_WB;
                     end else if (lane == 2'd3) begin
                        buf_ptr <= buf_ptr + 1'b1;
                        state   <= S_DREQ;
                     end
                  end
               end
               S_WB: begin
                  case (wb_kind)
                     WB_MID: state <= S_FETCH_A;
                     WB_LAST: begin
                        in_frame   <= 1'b0;
                        under_pend <= 1'b0;
                        state      <= (halt_pend || halt_i) ? S_IDLE : S_FETCH_A;
                     end
                     default: begin
                        in_frame   <= 1'b0;
                        under_pend <= 1'b0;
                        state      <= S_ERRB;
                     end
                  endcase
               end
               S_ERRB: if (tx_ready_i) state <= S_IDLE;
               default: state <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/txr_fetch_chk.sv
`timescale 1ns/1ps
module txr_fetch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       underrun_i,
   input logic       busy_o,
   input logic       mem_rd_o,
   input logic       mem_wr_o,
   input logic [31:0] mem_wdata_o,
   input logic       tx_valid_o,
   input logic       tx_ready_i,
   input logic [7:0] tx_data_o,
   input logic       tx_sof_o,
   input logic       tx_eof_o,
   input logic       tx_err_o
);
   // R1: an idle engine drives nothing
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!tx_valid_o && !mem_rd_o && !mem_wr_o));

   // R3: frame markers only travel on a valid beat
   a_r3_marks_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sof_o || tx_eof_o) |-> tx_valid_o);

   // R4: every write-back hands the descriptor back as used
   a_r4_wb_used: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> mem_wdata_o[31]);

   // R9: the error beat closes the frame with a zero byte
   a_r9_err_closes: assert property (@(posedge clk) disable iff (!rst_n)
      tx_err_o |-> (tx_eof_o && tx_data_o == 8'h00 && !tx_sof_o));

   // R13: a stalled beat is held
   a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i && !underrun_i) |=>
         (tx_valid_o && $stable(tx_data_o) && $stable(tx_eof_o) && $stable(tx_err_o)));

   // R4: memory port never reads and writes at once
   a_r4_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));
endmodule

bind txr_fetch txr_fetch_chk u_chk (
   .clk(clk), .rst_n(rst_n), .underrun_i(underrun_i), .busy_o(busy_o),
   .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o),
   .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
   .tx_sof_o(tx_sof_o), .tx_eof_o(tx_eof_o), .tx_err_o(tx_err_o)
);

// File: tb/sim_txr_fetch.sv
`timescale 1ns/1ps
module sim_txr_fetch;
   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, halt = 1'b0, underrun = 1'b0;
   logic busy, mrd, mwr, tx_valid, tx_sof, tx_eof, tx_err, tx_nocrc;
   logic tx_ready = 1'b1;
   logic ready_mode = 1'b0;
   logic [AW-1:0] maddr;
   logic [31:0] mwdata, mrdata;
   logic [7:0] tx_data;

   logic [31:0] mem [0:511];
   int wr_cnt = 0;
   int cyc = 0;
   int checks = 0, errors = 0;

   logic [7:0] cap_d   [0:127];
   logic       cap_sof [0:127];
   logic       cap_eof [0:127];
   logic       cap_err [0:127];
   logic       cap_nc  [0:127];
   int cap_n = 0;

   always #5 clk = ~clk;

   txr_fetch u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .halt_i(halt), .underrun_i(underrun),
      .busy_o(busy), .mem_rd_o(mrd), .mem_wr_o(mwr), .mem_addr_o(maddr),
      .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .tx_valid_o(tx_valid),
      .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_sof_o(tx_sof), .tx_eof_o(tx_eof),
      .tx_err_o(tx_err), .tx_nocrc_o(tx_nocrc)
   );

   // memory model, one cycle read latency
   always @(posedge clk) begin
      if (mrd) mrdata <= mem[maddr[8:0]];
      if (mwr) begin
         mem[maddr[8:0]] <= mwdata;
         wr_cnt <= wr_cnt + 1;
      end
   end

   // ready pattern, driven just after the edge
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1 tx_ready = ready_mode ? ((cyc % 3) != 0) : 1'b1;
   end

   // beat monitor on the falling edge
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready && cap_n < 128) begin
         cap_d[cap_n]   = tx_data;
         cap_sof[cap_n] = tx_sof;
         cap_eof[cap_n] = tx_eof;
         cap_err[cap_n] = tx_err;
         cap_nc[cap_n]  = tx_nocrc;
         cap_n = cap_n + 1;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected idle");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic logic [7:0] pat(int b);
      return 8'((b * 7 + 1) & 255);
   endfunction

   function automatic int buf_word(int idx);
      return 64 + 16 * idx;
   endfunction

   function automatic logic [7:0] exp_byte(int idx, int k);
      return pat(buf_word(idx) * 4 + k);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic set_desc(input int idx, input logic [31:0] ctrl);
      mem[2*idx]   = 32'(buf_word(idx) * 4);
      mem[2*idx+1] = ctrl;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic run(input bit with_halt);
      cap_n = 0;
      @(posedge clk); #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0; halt = with_halt;
      @(posedge clk); #2 halt = 1'b0;
      wait_idle();
      repeat (2) @(negedge clk);
   endtask

   // check n beats of buffer idx starting at capture position p
   task automatic chk_buf(input int p, input int idx, input int n, input bit sof0,
                          input bit eofn, input bit nc, input string tag);
      for (int k = 0; k < n; k++) begin
         chk(cap_d[p+k] == exp_byte(idx, k), {tag, " data"}, cap_d[p+k], exp_byte(idx, k));
         chk(cap_sof[p+k] == (sof0 && k == 0), {tag, " sof"}, cap_sof[p+k], sof0 && k == 0);
         chk(cap_eof[p+k] == (eofn && k == n-1), {tag, " eof"}, cap_eof[p+k], eofn && k == n-1);
         chk(cap_nc[p+k] == nc, {tag, " nocrc"}, cap_nc[p+k], nc);
         chk(cap_err[p+k] == 1'b0, {tag, " err"}, cap_err[p+k], 0);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!busy && !tx_valid && !mrd && !mwr, "R1 reset outputs", {busy, tx_valid, mrd, mwr}, 0);
   endtask

   task automatic t_used_start();
      set_desc(0, 32'h8000_8004);
      run(0);
      chk(cap_n == 0, "R2 no bytes on used start", cap_n, 0);
      chk(wr_cnt == 0, "R2 no writes on used start", wr_cnt, 0);
   endtask

   task automatic t_single();
      set_desc(0, 32'h0000_8006);
      set_desc(1, 32'h8000_0000);
      run(0);
      chk(cap_n == 6, "R3 beat count", cap_n, 6);
      chk_buf(0, 0, 6, 1, 1, 0, "R3 single frame");
      chk(mem[1] == 32'h8000_8006, "R4 write-back", mem[1], 32'h8000_8006);
      chk(mem[3] == 32'h8000_0000, "R6 stop at used", mem[3], 32'h8000_0000);
   endtask

   task automatic t_multi();
      set_desc(1, 32'h0001_0003);
      set_desc(2, 32'h0000_8005);
      set_desc(3, 32'h0000_8002);
      set_desc(4, 32'h8000_0000);
      ready_mode = 1'b1;
      run(0);
      ready_mode = 1'b0;
      chk(cap_n == 10, "R5 R6 beat count", cap_n, 10);
      chk_buf(0, 1, 3, 1, 0, 1, "R5 R8 R13 first buffer");
      chk_buf(3, 2, 5, 0, 1, 1, "R5 R8 second buffer");
      chk_buf(8, 3, 2, 1, 1, 0, "R6 R8 next frame");
      chk(mem[3] == 32'h8001_0003, "R4 mid buffer write-back", mem[3], 32'h8001_0003);
      chk(mem[7] == 32'h8000_8002, "R6 second frame write-back", mem[7], 32'h8000_8002);
   endtask

   task automatic t_wrap();
      set_desc(4, 32'h4000_8001);
      set_desc(0, 32'h0000_8001);
      set_desc(1, 32'h8000_0000);
      run(0);
      chk(cap_n == 2, "R7 beat count", cap_n, 2);
      chk_buf(0, 4, 1, 1, 1, 0, "R7 before wrap");
      chk_buf(1, 0, 1, 1, 1, 0, "R7 after wrap");
   endtask

   task automatic t_exhaust();
      set_desc(1, 32'h0000_0002);
      set_desc(2, 32'h8000_0000);
      run(0);
      chk(cap_n == 3, "R9 beat count", cap_n, 3);
      chk_buf(0, 1, 2, 1, 0, 0, "R9 partial");
      chk(cap_err[2] && cap_eof[2] && cap_d[2] == 0, "R9 error beat",
          {cap_err[2], cap_eof[2], cap_d[2]}, 10'h300);
      chk(mem[5] == 32'h8800_0000, "R9 exhaustion flag", mem[5], 32'h8800_0000);
      chk(!busy, "R9 idle", busy, 0);
      // index must still point at descriptor 2
      set_desc(2, 32'h0000_8001);
      set_desc(3, 32'h8000_0000);
      run(0);
      chk(cap_n == 1, "R12 resume count", cap_n, 1);
      chk_buf(0, 2, 1, 1, 1, 0, "R12 R9 resume at same index");
   endtask

   task automatic t_underrun();
      int w0;
      set_desc(3, 32'h0000_8028);
      set_desc(4, 32'h8000_0000);
      cap_n = 0;
      @(posedge clk); #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      for (int i = 0; i < 500 && cap_n < 5; i++) @(negedge clk);
      @(posedge clk); #2 underrun = 1'b1;
      @(posedge clk); #2 underrun = 1'b0;
      wait_idle();
      repeat (2) @(negedge clk);
      chk(cap_n >= 6 && cap_n < 40, "R10 aborted early", cap_n, 6);
      chk(cap_err[cap_n-1] && cap_eof[cap_n-1], "R10 error beat",
          {cap_err[cap_n-1], cap_eof[cap_n-1]}, 2'b11);
      chk_buf(0, 3, cap_n - 1, 1, 0, 0, "R10 bytes before abort");
      chk(mem[7] == 32'h9000_8028, "R10 underrun flag", mem[7], 32'h9000_8028);
      // pulse while idle: nothing happens
      w0 = wr_cnt;
      cap_n = 0;
      @(posedge clk); #2 underrun = 1'b1;
      @(posedge clk); #2 underrun = 1'b0;
      repeat (5) @(negedge clk);
      chk(cap_n == 0 && wr_cnt == w0 && !busy, "R10 idle underrun ignored", cap_n, 0);
      // index advanced past descriptor 3
      set_desc(4, 32'h0000_8001);
      set_desc(5, 32'h8000_0000);
      run(0);
      chk(cap_n == 1, "R10 advance count", cap_n, 1);
      chk_buf(0, 4, 1, 1, 1, 0, "R10 index advanced");
   endtask

   task automatic t_halt();
      set_desc(5, 32'h0000_8004);
      set_desc(6, 32'h0000_8004);
      set_desc(7, 32'h8000_0000);
      run(1);
      chk(cap_n == 4, "R11 only current frame", cap_n, 4);
      chk_buf(0, 5, 4, 1, 1, 0, "R11 frame completes");
      chk(mem[11] == 32'h8000_8004, "R11 write-back done", mem[11], 32'h8000_8004);
      chk(mem[13] == 32'h0000_8004, "R11 next untouched", mem[13], 32'h0000_8004);
      chk(!busy, "R11 busy low", busy, 0);
      run(0);
      chk(cap_n == 4, "R11 R12 restart count", cap_n, 4);
      chk_buf(0, 6, 4, 1, 1, 0, "R11 R12 restart");
   endtask

   initial begin
      for (int w = 0; w < 512; w++)
         mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
      for (int i = 0; i < 16; i++) set_desc(i, 32'h8000_0000);
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_used_start();
      t_single();
      t_multi();
      t_wrap();
      t_exhaust();
      t_underrun();
      t_halt();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule